// File: doc/BRIEF.md
# Self-Synchronising Byte Descrambler with Clock-Crossing Output Queue

This block sits at the end of a receive chain. It takes the decoded byte stream and undoes the randomising applied at the transmitter. The transmitter uses a self-synchronising scrambler built on a 20-stage maximal-length register. The descrambler register is filled with the received bits themselves, so the block needs no seed and no frame alignment. After 20 bits have passed, its output matches the original data, whatever state the transmit scrambler started in.

Descrambled bytes are written, in the write clock domain, into a 16-entry queue that crosses to an independent read clock. The read side has no flow control. It pops one byte on every read clock edge while the queue holds data, and it presents that byte with a one-cycle valid pulse. There is no back-pressure towards the source. If a byte arrives while the queue is full, the byte is discarded and a sticky overflow flag is raised.

Top module: `byte_derand_cdc`

## Requirements
- R1: For each accepted byte, bits are processed from bit 7 down to bit 0. Each output bit equals the input bit XOR the received bit 3 steps earlier XOR the received bit 20 steps earlier. The 20-bit history register is cleared by the write reset and shifts in the received (scrambled) bits.
- R2: Whatever the transmit scrambler's initial state, every output byte from the fourth accepted byte onward (after at least 20 received bits) equals the original plaintext byte.
- R3: When `in_valid` is low, `in_byte` is ignored. Neither the history register nor the queue changes, so the descrambled stream continues unbroken across idle cycles.
- R4: Accepted bytes leave on `out_data` in the order they were written. Each byte comes with a single `rd_clk` cycle of `out_valid`. Whenever the queue is not empty, one byte is popped per `rd_clk` edge.
- R5: A byte presented with `in_valid` while the queue is full is discarded. `overflow` (in the `wr_clk` domain) then rises and stays high until `wr_rst_n` is asserted.
- R6: While in reset, `out_valid` is 0 and `overflow` is 0.
- R7: The queue holds exactly 16 bytes. While the read side is held in reset, the first 16 of a back-to-back burst are kept and later bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Symbol-rate write clock |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write domain |
| in_byte | input | 8 | Scrambled input byte |
| in_valid | input | 1 | Qualifies `in_byte` on this `wr_clk` edge |
| overflow | output | 1 | Sticky flag: a byte was dropped because the queue was full |
| rd_clk | input | 1 | Independent user read clock |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read domain |
| out_data | output | 8 | Descrambled output byte |
| out_valid | output | 1 | High for one `rd_clk` cycle per byte on `out_data` |

## Verification
The assertions assume two things. First, each reset is asserted before its domain's first clock edge. Second, the queue pointers are exchanged only as Gray codes, so a pointer seen by the other domain moves by at most one bit per cycle.

In the normal phases, the stimulus spaces bytes at least eight write cycles apart. The read clock runs four times slower than the write clock, so the read side drains faster than the source fills it. These phases therefore never reach the full condition.

Overflow is produced deliberately, by holding the read domain in reset during a back-to-back burst. The exact count of kept bytes is then fixed and predictable.

// File: rtl/byte_derand_cdc.sv
module byte_derand_cdc #(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int SR_LEN = 20,
  parameter int TAP_A  = 3
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic [DW-1:0] in_byte,
  input  logic          in_valid,
  output logic          overflow,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  localparam int DEPTH = 1 << AW;

  logic [SR_LEN-1:0] sr, sr_nx;
  logic [DW-1:0]     plain;
  logic [DW-1:0]     mem [DEPTH];

  logic [AW:0] wbin, wgray, rq1, rq2, wbin_n;
  logic [AW:0] rbin, rgray, wq1, wq2, rbin_n;
  logic        full, empty, wr_en;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  always_comb begin
    sr_nx = sr;
    plain = '0;
    for (int i = DW - 1; i >= 0; i--) begin
      plain[i] = in_byte[i] ^ sr_nx[TAP_A-1] ^ sr_nx[SR_LEN-1];
      sr_nx    = {sr_nx[SR_LEN-2:0], in_byte[i]};
    end
  end

  assign full   = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
  assign wr_en  = in_valid && !full;
  assign wbin_n = wbin + 1'b1;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      sr       <= '0;
      wbin     <= '0;
      wgray    <= '0;
      rq1      <= '0;
      rq2      <= '0;
      overflow <= 1'b0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (in_valid) sr <= sr_nx;
      if (wr_en) begin
        wbin  <= wbin_n;
        wgray <= to_gray(wbin_n);
      end
      if (in_valid && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= plain;
  end

  AST_DROP_FLAGS: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (in_valid && full) |=> overflow);                                   // R5
  AST_FLAG_STICKY: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    overflow |=> overflow);                                             // R5
  AST_IDLE_HOLDS: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !in_valid |=> ($stable(sr) && $stable(wbin)));                      // R3
  AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $onehot0(wgray ^ $past(wgray)));                                    // R4

  assign empty  = (rgray == wq2);
  assign rbin_n = rbin + 1'b1;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin      <= '0;
      rgray     <= '0;
      wq1       <= '0;
      wq2       <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      out_valid <= !empty;
      if (!empty) begin
        out_data <= mem[rbin[AW-1:0]];
        rbin     <= rbin_n;
        rgray    <= to_gray(rbin_n);
      end
    end
  end

  AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $onehot0(rgray ^ $past(rgray)));                                    // R4
  AST_POP_ADVANCES: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_valid |-> (rbin != $past(rbin)));                               // R4
endmodule

// File: tb/test_byte_derand_cdc.sv
module test_byte_derand_cdc;
  logic       wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic [7:0] in_byte = 0;
  logic       in_valid = 0;
  logic       overflow, out_valid;
  logic [7:0] out_data;

  int nchk = 0, nerr = 0;
  logic [19:0] tx_s, rx_r;
  logic [7:0]  recv[$], exp_m[$], exp_p[$];

  always #2.5 wclk = ~wclk;
  always #10  rclk = ~rclk;

  byte_derand_cdc i_byte_derand_cdc (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .in_byte(in_byte), .in_valid(in_valid),
    .overflow(overflow), .rd_clk(rclk), .rd_rst_n(rrst_n),
    .out_data(out_data), .out_valid(out_valid));

  always @(negedge rclk) if (rrst_n && out_valid) recv.push_back(out_data);

  function automatic logic [7:0] scr(input logic [7:0] p, inout logic [19:0] s);
    logic [7:0] c;
    for (int i = 7; i >= 0; i--) begin
      c[i] = p[i] ^ s[2] ^ s[19];
      s = {s[18:0], c[i]};
    end
    return c;
  endfunction

  function automatic logic [7:0] dscr(input logic [7:0] c, inout logic [19:0] r);
    logic [7:0] d;
    for (int i = 7; i >= 0; i--) begin
      d[i] = c[i] ^ r[2] ^ r[19];
      r = {r[18:0], c[i]};
    end
    return d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic reset_all();
    in_valid = 0; wrst_n = 0; rrst_n = 0;
    repeat (4) @(negedge rclk);
    check("R6 out_valid in reset", out_valid, 0);
    check("R6 overflow in reset", overflow, 0);
    recv.delete(); exp_m.delete(); exp_p.delete();
    rx_r = 0;
    @(negedge wclk); wrst_n = 1;
    @(negedge rclk); rrst_n = 1;
  endtask

  task automatic send(input logic [7:0] p, input int gap);
    logic [7:0] c;
    c = scr(p, tx_s);
    exp_p.push_back(p);
    exp_m.push_back(dscr(c, rx_r));
    @(negedge wclk); in_valid = 1; in_byte = c;
    for (int g = 0; g < gap; g++) begin
      @(negedge wclk); in_valid = 0; in_byte = 8'($urandom);
    end
  endtask

  task automatic compare(input string req, input bit plain_check);
    repeat (40) @(negedge rclk);
    check({req, " R4 byte count"}, recv.size(), exp_m.size());
    for (int i = 0; i < recv.size() && i < exp_m.size(); i++) begin
      check({req, " R1 model byte"}, recv[i], exp_m[i]);
      if (plain_check && i >= 3) check({req, " R2 plaintext"}, recv[i], exp_p[i]);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R7/R5: read side held in reset, 20 back-to-back bytes
    reset_all();
    rrst_n = 0;
    tx_s = 20'hA5C3F;
    for (int i = 0; i < 20; i++) begin
      logic [7:0] c;
      c = scr(8'($urandom), tx_s);
      if (i < 16) exp_m.push_back(dscr(c, rx_r));
      @(negedge wclk); in_valid = 1; in_byte = c;
    end
    @(negedge wclk); in_valid = 0;
    check("R7 overflow after 20 into 16", overflow, 1);
    check("R7 nothing read while held", recv.size(), 0);
    @(negedge rclk); rrst_n = 1;
    compare("R7 kept first 16", 0);
    repeat (20) @(negedge wclk);
    check("R5 overflow sticky", overflow, 1);

    // R1/R2: random traffic with random gaps, random scrambler start
    reset_all();
    tx_s = 20'($urandom) | 20'h1;
    for (int i = 0; i < 300; i++) send(8'($urandom), 7 + int'($urandom % 4));
    compare("R2 random", 1);
    check("R5 no false overflow", overflow, 0);

    // Directed: zeros from all-ones scrambler state
    reset_all();
    tx_s = 20'hFFFFF;
    for (int i = 0; i < 40; i++) send(8'h00, 8);
    compare("R2 zeros", 1);

    // R3: long idle stretch with garbage on in_byte
    reset_all();
    tx_s = 20'h12345;
    for (int i = 0; i < 5; i++) send(8'($urandom), 8);
    repeat (60) @(negedge wclk) in_byte = 8'($urandom);
    for (int i = 0; i < 5; i++) send(8'($urandom), 8);
    compare("R3 idle ignored", 1);

    // R4: burst of 12 back-to-back, below capacity
    reset_all();
    tx_s = 20'h0BEEF;
    for (int i = 0; i < 12; i++) send(8'($urandom), 0);
    @(negedge wclk); in_valid = 0;
    compare("R4 burst", 1);
    check("R5 burst no overflow", overflow, 0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #500000;
    nchk++; nerr++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule